// File: doc/BRIEF.md
# Endpoint packet memory allocator

This block divides one shared packet RAM among up to seven USB endpoints. Each endpoint holds a packet size code, a bank count and an active bit. Its window is the packet size multiplied by the bank count. An endpoint counts as allocated when it is active and its bank count is nonzero. Windows are packed in ascending endpoint order: when an endpoint is placed, its base pointer starts right after the window of the nearest lower-numbered endpoint whose window is nonzero.

Placement happens only for the endpoint that a configuration write or an activation change addresses. Every other endpoint keeps the base and window it already has. Because of this, when a lower endpoint grows or is re-allocated, its window can run into a higher endpoint's window. The per-endpoint mapped flag checks only that endpoint's own limits and whether its window fits in the RAM, so it does not see such collisions. A separate conflict output marks every endpoint whose window overlaps the window of some lower endpoint.

Top module: `ep_mem_alloc`

## Requirements
- R1: After reset, every base pointer and window size is 0, and every mapped and conflict bit is 0.
- R2: An allocated endpoint's window size is (8 << size_code) * banks. The 3-bit size_code values 0..7 stand for 8..1024 bytes, and banks is 1..3.
- R3: When an endpoint is placed, its base is base+window of the highest-numbered lower endpoint whose window is nonzero, or 0 if there is none. Endpoint 0's base is therefore always 0. New values appear on the outputs in the cycle after the edge that takes the write.
- R4: A write to endpoint k changes only endpoint k's base, window and mapped bit. Every higher endpoint keeps its base, even if that creates an overlap.
- R5: An endpoint with a bank count of 0, or one that is inactive, gets a window of 0 and a mapped bit of 0.
- R6: The mapped bit is 1 only if the endpoint is allocated, size_code does not exceed its limit, banks does not exceed its limit, and base+window <= 4096. The limits are: endpoint 0, code 3 and 1 bank; endpoints 1 and 2, code 6 and 2 banks; endpoints 3 to 6, code 7 and 3 banks.
- R7: The mapped bit does not depend on overlap. An endpoint that overlaps another can still show mapped = 1.
- R8: conflict[k] is 1 if and only if window k is nonzero and overlaps a nonzero window of some lower endpoint. conflict[0] is always 0.
- R9: If a configuration write and an activation change arrive in the same cycle, the activation change is ignored. Any endpoint index of 7 or above is ignored.
- R10: Deactivating an endpoint and then reactivating it with the same configuration, while the lower endpoints are unchanged, restores the same base and window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ep_i | input | 3 | Endpoint index for the configuration write |
| cfg_size_i | input | 3 | Packet size code (8 << code bytes) |
| cfg_banks_i | input | 2 | Bank count; 0 releases the endpoint |
| act_we_i | input | 1 | Activation change strobe |
| act_ep_i | input | 3 | Endpoint index for the activation change |
| act_en_i | input | 1 | New active state |
| base_o | output | 112 | Base pointers, 16 bits per endpoint; endpoint k is at [16k+15:16k] |
| win_o | output | 112 | Window sizes, 16 bits per endpoint |
| mapped_o | output | 7 | Per-endpoint mapped flag |
| conflict_o | output | 7 | Per-endpoint overlap with a lower window |

## Verification
The bench targets three cases. The first is a lower endpoint growing under a higher one that was already placed: a design that shifts the higher base would hide the conflict, and a design that misses it would leave conflict low. The second is a chain of large windows that runs past 4096 bytes: a design that ignores the end address would keep mapped high. The third is an overlapping endpoint that is within its own limits: a design that folds overlap into the mapped decision would clear mapped there. Further cases cover simultaneous strobes, out-of-range indices, and a deactivate/reactivate round trip. In those cases a wrong priority or a missing range check shows up as a changed base on an endpoint that should not have moved.

// File: rtl/ep_alloc_pkg.sv
package ep_alloc_pkg;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned BANK_W = 2;

  function automatic logic [CODE_W-1:0] max_code(input int unsigned ep);
    if (ep == 0) return CODE_W'(3);
    else if (ep < 3) return CODE_W'(6);
    else return CODE_W'(7);
  endfunction

  function automatic logic [BANK_W-1:0] max_banks(input int unsigned ep);
    if (ep == 0) return BANK_W'(1);
    else if (ep < 3) return BANK_W'(2);
    else return BANK_W'(3);
  endfunction
endpackage

// File: rtl/ep_alloc_place.sv
module ep_alloc_place #(
  parameter int unsigned N_EP = 7,
  parameter int unsigned AW   = 16
) (
  input  logic [N_EP-1:0][AW-1:0] base_i,
  input  logic [N_EP-1:0][AW-1:0] win_i,
  output logic [N_EP-1:0][AW-1:0] prev_end_o
);
  for (genvar k = 0; k < N_EP; k++) begin : g_ep
    always_comb begin
      prev_end_o[k] = '0;
      for (int j = 0; j < k; j++) begin
        if (win_i[j] != '0) prev_end_o[k] = base_i[j] + win_i[j];
      end
    end
  end
endmodule

// File: rtl/ep_alloc_check.sv
module ep_alloc_check
  import ep_alloc_pkg::*;
#(
  parameter int unsigned N_EP      = 7,
  parameter int unsigned AW        = 16,
  parameter int unsigned RAM_BYTES = 4096,
  parameter int unsigned EPW       = 3
) (
  input  logic [EPW-1:0]    ep_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [BANK_W-1:0] banks_i,
  input  logic              active_i,
  input  logic [AW-1:0]     base_i,
  output logic [AW-1:0]     win_o,
  output logic              mapped_o
);
  logic          alloc;
  logic [AW-1:0] pkt;
  logic [AW:0]   end_addr;
  logic          lim_ok;

  always_comb begin
    alloc    = active_i && (banks_i != '0);
    pkt      = AW'(8) << code_i;
    win_o    = alloc ? AW'(pkt * AW'(banks_i)) : '0;
    end_addr = {1'b0, base_i} + {1'b0, win_o};
    lim_ok   = (code_i <= max_code(int'(ep_i))) && (banks_i <= max_banks(int'(ep_i)));
    mapped_o = alloc && lim_ok && (end_addr <= (AW+1)'(RAM_BYTES));
  end
endmodule

// File: rtl/ep_alloc_overlap.sv
module ep_alloc_overlap #(
  parameter int unsigned N_EP = 7,
  parameter int unsigned AW   = 16
) (
  input  logic [N_EP-1:0][AW-1:0] base_i,
  input  logic [N_EP-1:0][AW-1:0] win_i,
  output logic [N_EP-1:0]         conflict_o
);
  for (genvar k = 0; k < N_EP; k++) begin : g_ep
    logic [AW:0] hi_k;
    assign hi_k = {1'b0, base_i[k]} + {1'b0, win_i[k]};
    always_comb begin
      conflict_o[k] = 1'b0;
      for (int j = 0; j < k; j++) begin
        if (win_i[k] != '0 && win_i[j] != '0 &&
            {1'b0, base_i[j]} < hi_k &&
            {1'b0, base_i[k]} < ({1'b0, base_i[j]} + {1'b0, win_i[j]}))
          conflict_o[k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ep_mem_alloc.sv
module ep_mem_alloc
  import ep_alloc_pkg::*;
#(
  parameter int unsigned N_EP      = 7,
  parameter int unsigned RAM_BYTES = 4096
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [2:0]           cfg_ep_i,
  input  logic [2:0]           cfg_size_i,
  input  logic [1:0]           cfg_banks_i,
  input  logic                 act_we_i,
  input  logic [2:0]           act_ep_i,
  input  logic                 act_en_i,
  output logic [N_EP*16-1:0]   base_o,
  output logic [N_EP*16-1:0]   win_o,
  output logic [N_EP-1:0]      mapped_o,
  output logic [N_EP-1:0]      conflict_o
);
  localparam int unsigned AW  = 16;
  localparam int unsigned EPW = 3;

  logic [N_EP-1:0][CODE_W-1:0] code_r;
  logic [N_EP-1:0][BANK_W-1:0] banks_r;
  logic [N_EP-1:0]             act_r;
  logic [N_EP-1:0][AW-1:0]     base_r;
  logic [N_EP-1:0][AW-1:0]     win_r;
  logic [N_EP-1:0]             map_r;
  logic [N_EP-1:0][AW-1:0]     prev_end;

  logic              cfg_hit, act_hit, evt;
  logic [EPW-1:0]    sel;
  logic [CODE_W-1:0] n_code;
  logic [BANK_W-1:0] n_banks;
  logic              n_act;
  logic [AW-1:0]     n_base, n_win;
  logic              n_map;

  assign cfg_hit = cfg_we_i && (int'(cfg_ep_i) < N_EP);
  assign act_hit = !cfg_we_i && act_we_i && (int'(act_ep_i) < N_EP);
  assign evt     = cfg_hit || act_hit;
  assign sel     = cfg_we_i ? cfg_ep_i : act_ep_i;

  always_comb begin
    n_code  = '0;
    n_banks = '0;
    n_act   = 1'b0;
    n_base  = '0;
    for (int k = 0; k < N_EP; k++) begin
      if (int'(sel) == k) begin
        n_code  = cfg_hit ? cfg_size_i  : code_r[k];
        n_banks = cfg_hit ? cfg_banks_i : banks_r[k];
        n_act   = cfg_hit ? act_r[k]    : act_en_i;
        n_base  = prev_end[k];
      end
    end
  end

  ep_alloc_place #(.N_EP(N_EP), .AW(AW)) u_place (
    .base_i    (base_r),
    .win_i     (win_r),
    .prev_end_o(prev_end)
  );

  ep_alloc_check #(.N_EP(N_EP), .AW(AW), .RAM_BYTES(RAM_BYTES), .EPW(EPW)) u_check (
    .ep_i    (sel),
    .code_i  (n_code),
    .banks_i (n_banks),
    .active_i(n_act),
    .base_i  (n_base),
    .win_o   (n_win),
    .mapped_o(n_map)
  );

  ep_alloc_overlap #(.N_EP(N_EP), .AW(AW)) u_ovl (
    .base_i    (base_r),
    .win_i     (win_r),
    .conflict_o(conflict_o)
  );

  for (genvar k = 0; k < N_EP; k++) begin : g_ep
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        code_r[k]  <= '0;
        banks_r[k] <= '0;
        act_r[k]   <= 1'b0;
        base_r[k]  <= '0;
        win_r[k]   <= '0;
        map_r[k]   <= 1'b0;
      end else if (evt && int'(sel) == k) begin
        code_r[k]  <= n_code;
        banks_r[k] <= n_banks;
        act_r[k]   <= n_act;
        base_r[k]  <= n_base;
        win_r[k]   <= n_win;
        map_r[k]   <= n_map;
      end
    end
    assign base_o[k*AW +: AW] = base_r[k];
    assign win_o[k*AW +: AW]  = win_r[k];
  end

  assign mapped_o = map_r;
endmodule

// File: rtl/ep_mem_alloc_chk.sv
module ep_mem_alloc_chk #(
  parameter int unsigned N_EP      = 7,
  parameter int unsigned RAM_BYTES = 4096
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_we_i,
  input logic [2:0]         cfg_ep_i,
  input logic               act_we_i,
  input logic [2:0]         act_ep_i,
  input logic               act_en_i,
  input logic [N_EP*16-1:0] base_o,
  input logic [N_EP*16-1:0] win_o,
  input logic [N_EP-1:0]    mapped_o,
  input logic [N_EP-1:0]    conflict_o
);
  // R3
  ep0_base_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_o[15:0] == 16'd0);

  // R8
  ep0_no_conflict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conflict_o[0]);

  for (genvar k = 0; k < N_EP; k++) begin : g_k
    // R5
    mapped_needs_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mapped_o[k] |-> win_o[k*16 +: 16] != 16'd0);

    // R8
    empty_no_conflict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      win_o[k*16 +: 16] == 16'd0 |-> !conflict_o[k]);

    // R6
    mapped_fits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mapped_o[k] |-> (17'(base_o[k*16 +: 16]) + 17'(win_o[k*16 +: 16])) <= 17'(RAM_BYTES));

    // R5
    deact_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_we_i && act_we_i && int'(act_ep_i) == k && !act_en_i)
      |=> (win_o[k*16 +: 16] == 16'd0 && !mapped_o[k]));

    for (genvar j = k + 1; j < N_EP; j++) begin : g_j
      // R4
      higher_base_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && int'(cfg_ep_i) == k) |=> $stable(base_o[j*16 +: 16]));
    end
  end
endmodule

bind ep_mem_alloc ep_mem_alloc_chk #(.N_EP(N_EP), .RAM_BYTES(RAM_BYTES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_we_i  (cfg_we_i),
  .cfg_ep_i  (cfg_ep_i),
  .act_we_i  (act_we_i),
  .act_ep_i  (act_ep_i),
  .act_en_i  (act_en_i),
  .base_o    (base_o),
  .win_o     (win_o),
  .mapped_o  (mapped_o),
  .conflict_o(conflict_o)
);

// File: tb/sim_ep_mem_alloc.sv
module sim_ep_mem_alloc;
  localparam int N = 7;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           cfg_we_i = 1'b0;
  logic [2:0]     cfg_ep_i = '0;
  logic [2:0]     cfg_size_i = '0;
  logic [1:0]     cfg_banks_i = '0;
  logic           act_we_i = 1'b0;
  logic [2:0]     act_ep_i = '0;
  logic           act_en_i = 1'b0;
  logic [N*16-1:0] base_o, win_o;
  logic [N-1:0]   mapped_o, conflict_o;

  int n_vec = 0, n_bad = 0;

  int m_code[N], m_banks[N], m_act[N], m_base[N], m_win[N], m_map[N];

  always #10 clk_i = ~clk_i;

  ep_mem_alloc u0 (.*);

  function automatic int lim_code(int k); return k == 0 ? 3 : (k < 3 ? 6 : 7); endfunction
  function automatic int lim_banks(int k); return k == 0 ? 1 : (k < 3 ? 2 : 3); endfunction

  function automatic void place(int k);
    int pe = 0;
    for (int j = 0; j < k; j++) if (m_win[j] != 0) pe = m_base[j] + m_win[j];
    m_base[k] = pe;
    m_win[k]  = (m_act[k] != 0 && m_banks[k] != 0) ? (8 << m_code[k]) * m_banks[k] : 0;
    m_map[k]  = (m_win[k] != 0 && m_code[k] <= lim_code(k) && m_banks[k] <= lim_banks(k)
                 && pe + m_win[k] <= 4096) ? 1 : 0;
  endfunction

  function automatic int exp_conf(int k);
    if (m_win[k] == 0) return 0;
    for (int j = 0; j < k; j++)
      if (m_win[j] != 0 && m_base[j] < m_base[k] + m_win[k] && m_base[k] < m_base[j] + m_win[j])
        return 1;
    return 0;
  endfunction

  task automatic check_all(string req);
    for (int k = 0; k < N; k++) begin
      int ab = int'(base_o[k*16 +: 16]);
      int aw = int'(win_o[k*16 +: 16]);
      int am = int'(mapped_o[k]);
      int ac = int'(conflict_o[k]);
      n_vec++;
      if (ab != m_base[k] || aw != m_win[k] || am != m_map[k] || ac != exp_conf(k)) begin
        n_bad++;
        $display("FAIL %s ep%0d: base/win/map/conf actual %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                 req, k, ab, aw, am, ac, m_base[k], m_win[k], m_map[k], exp_conf(k));
      end
    end
  endtask

  // one cycle: drive at negedge, model at posedge, check at following negedge
  task automatic step(bit cw, int ce, int cs, int cb, bit aw, int ae, bit aen, string req);
    @(negedge clk_i);
    cfg_we_i = cw; cfg_ep_i = 3'(ce); cfg_size_i = 3'(cs); cfg_banks_i = 2'(cb);
    act_we_i = aw; act_ep_i = 3'(ae); act_en_i = aen;
    @(posedge clk_i);
    if (cw) begin
      if (ce < N) begin m_code[ce] = cs; m_banks[ce] = cb; place(ce); end
    end else if (aw && ae < N) begin
      m_act[ae] = aen; place(ae);
    end
    @(negedge clk_i);
    cfg_we_i = 1'b0; act_we_i = 1'b0;
    check_all(req);
  endtask

  task automatic cfg(int e, int c, int b, string req); step(1, e, c, b, 0, 0, 0, req); endtask
  task automatic act(int e, bit en, string req);       step(0, 0, 0, 0, 1, e, en, req); endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    for (int k = 0; k < N; k++) begin
      m_code[k] = 0; m_banks[k] = 0; m_act[k] = 0; m_base[k] = 0; m_win[k] = 0; m_map[k] = 0;
    end
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    int unsigned seed = 32'h5eed_1234;
    void'($urandom(seed));
    do_reset();
    check_all("R1");

    // R2 R3: pack ep0..ep2 in order
    act(0, 1, "R5"); cfg(0, 3, 1, "R2");
    act(1, 1, "R3"); cfg(1, 6, 2, "R3");
    act(2, 1, "R3"); cfg(2, 4, 1, "R3");
    // R4 R7 R8: grow ep1 under already-placed ep2
    cfg(1, 6, 2, "R4");
    cfg(0, 3, 1, "R4");
    act(1, 0, "R5"); act(1, 1, "R10");
    cfg(1, 5, 1, "R4");
    cfg(1, 6, 2, "R8");
    cfg(2, 4, 1, "R7");
    // R6: limits and RAM overflow
    cfg(0, 4, 1, "R6"); cfg(0, 3, 2, "R6"); cfg(0, 3, 1, "R6");
    act(3, 1, "R6"); cfg(3, 7, 3, "R6");
    act(4, 1, "R6"); cfg(4, 7, 3, "R6");
    act(5, 1, "R6"); cfg(5, 0, 1, "R6");
    // R5: zero banks
    cfg(4, 7, 0, "R5");
    // R9: simultaneous strobes and bad index
    step(1, 2, 2, 1, 1, 1, 0, "R9");
    cfg(7, 7, 3, "R9");
    act(7, 0, "R9");
    // R10: round trip
    act(3, 0, "R10"); act(3, 1, "R10");

    do_reset();
    check_all("R1");
    for (int i = 0; i < 3000; i++) begin
      int kind = int'($urandom_range(0, 9));
      int e    = int'($urandom_range(0, 7));
      if (kind < 5)      cfg(e, int'($urandom_range(0, 7)), int'($urandom_range(0, 3)), "R2");
      else if (kind < 8) act(e, 1'($urandom_range(0, 3) != 0), "R3");
      else               step(1, e, int'($urandom_range(0, 5)), int'($urandom_range(0, 3)),
                              1, int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), "R9");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule